// File: doc/BRIEF.md
# Clock-Crossing Task Queue Interface

This unit connects a host's word-addressed register port to a task scheduling core that runs on a slower clock. It provides three queues:

- **New-task queue.** The host writes task descriptors into it, and the core drains them.
- **Ready-task queue.** The core pushes ready tasks into it, and the host reads them back.
- **Finished-task queue.** The host writes the identifiers of completed tasks into it, and the core drains them.

Every queue is an asynchronous FIFO with Gray-coded pointers that cross between the two clocks. Each queue also has a status word at the address after its data port. The status word tells the host whether it may access the queue and how many entries the queue holds. Because the occupancy is reported, the host can make several transfers after one status read.

A task descriptor is a packet of n+1 words, where n is the task's argument count. The first word carries the function pointer in its upper bits and n in its low byte. On the core side, a framer marks the first and the last word of each packet. It pulses a completion strobe once the final word of the packet has been taken by the core.

A ready-task entry is one word that the core packs from a function pointer and a pool index. A finished-task notification is one word that holds a task identifier.

Host accesses that cannot be served are dropped, and each one sets a sticky error bit in that queue's status word:
- a write to a full new-task or finished-task queue;
- a read from an empty ready-task queue.

Top module: `task_mbox_if`

## Requirements
- R1: Host word addresses decode as follows. 0 is new-task data and 1 is its status. 2 is ready-task data and 3 is its status. 4 is finished-task data and 5 is its status. A read of any other address returns zero.
- R2: A status word has bit 31 set when the host may access the queue: space is free for the new-task and finished-task queues, and data is present for the ready-task queue. Bit 30 is the sticky error bit. Bits 15:0 hold the occupancy in entries. All other bits are zero.
- R3: Words written to the new-task data port reach the core in order on `c_new_word`. While the core is not popping, the new-task status occupancy counts the words that have been written.
- R4: In a descriptor, bits 7:0 of the first word hold the argument count n. `c_new_first` marks word 0 and `c_new_last` marks word n of the packet. `c_desc_done` pulses for one core cycle, on the cycle after the last word is popped, and never at any other time.
- R5: Words that the core pushes into the ready-task queue are returned in order by host reads of address 2. The read data is valid on the cycle after the read strobe. `c_rdy_full` rises once the queue holds 2^AW entries, and a push made while the queue is full is dropped.
- R6: Identifiers written to address 4 reach the core in order on `c_fin_id`, each marked by `c_fin_valid`.
- R7: A host write to a full new-task or finished-task queue is dropped. The occupancy stays at 2^AW, and the error bit of that queue is set.
- R8: A host read of the ready-task data port while that queue is empty returns zero and sets the ready-task error bit.
- R9: After reset, the new-task and finished-task status words read 0x8000_0000 and the ready-task status word reads 0. No core-side valid output is set.
- R10: An error bit stays set until reset. An error in one queue leaves the error bits of the other queues clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host-side clock |
| h_rst_n | input | 1 | Host-side asynchronous reset, active low |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | 3 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered, valid one cycle after `h_rd_en` |
| c_clk | input | 1 | Core-side clock |
| c_rst_n | input | 1 | Core-side asynchronous reset, active low |
| c_new_pop | input | 1 | Core takes the current descriptor word |
| c_new_valid | output | 1 | A descriptor word is available |
| c_new_word | output | 32 | Current descriptor word |
| c_new_first | output | 1 | Current word is the first word of a descriptor |
| c_new_last | output | 1 | Current word is the last word of a descriptor |
| c_desc_done | output | 1 | One-cycle pulse after a complete descriptor has been taken |
| c_rdy_push | input | 1 | Core pushes a ready-task word |
| c_rdy_word | input | 32 | Ready-task word (function pointer and pool index) |
| c_rdy_full | output | 1 | Ready-task queue is full |
| c_fin_pop | input | 1 | Core takes the current finished-task identifier |
| c_fin_valid | output | 1 | A finished-task identifier is available |
| c_fin_id | output | 32 | Current finished-task identifier |

## Verification
The assertions check four properties on every cycle:
- the host-side occupancy of both host-written queues never exceeds the queue depth;
- a read of an empty ready-task queue returns zero;
- error bits never clear outside reset;
- the descriptor-complete strobe follows only the pop of a final word.

Only the bench's scenarios can show the remaining behaviour: ordering across the clock crossing, the exact occupancy values seen through the status words, and framing over a sweep of argument counts. In that sweep the host writer is throttled by its own status polling while the core drains the queue concurrently.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 16;

  localparam logic [2:0] A_NEW_DATA = 3'd0;
  localparam logic [2:0] A_NEW_STAT = 3'd1;
  localparam logic [2:0] A_RDY_DATA = 3'd2;
  localparam logic [2:0] A_RDY_STAT = 3'd3;
  localparam logic [2:0] A_FIN_DATA = 3'd4;
  localparam logic [2:0] A_FIN_STAT = 3'd5;

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // access flag in bit 31, sticky error in bit 30, occupancy in bits 15:0
  function automatic logic [WORD_W-1:0] status_word(input logic ok, input logic err,
                                                    input logic [CNT_W-1:0] occ);
    return {ok, err, 14'd0, occ};
  endfunction
endpackage

// File: rtl/tmb_async_fifo.sv
module tmb_async_fifo #(
  parameter int unsigned W              = 32,
  parameter int unsigned AW             = 4,
  parameter bit          HOST_IS_WRITER = 1'b1
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wen,
  input  logic [W-1:0] wdata,
  output logic         wfull,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         ren,
  output logic [W-1:0] rdata,
  output logic         rempty,
  output logic [15:0]  host_occ
);
  import tmb_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w1, rgray_w2, wgray_r1, wgray_r2;
  logic [PW-1:0] rbin_w, wbin_r, wocc, rocc;
  logic          push, pop;

  assign rbin_w = PW'(gray2bin(CNT_W'(rgray_w2)));
  assign wbin_r = PW'(gray2bin(CNT_W'(wgray_r2)));
  assign wocc   = wbin - rbin_w;
  assign rocc   = wbin_r - rbin;
  assign wfull  = (wocc == PW'(DEPTH));
  assign rempty = (rocc == '0);
  assign push   = wen & ~wfull;
  assign pop    = ren & ~rempty;
  assign rdata  = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rgray_w1 <= '0; rgray_w2 <= '0;
    end else begin
      rgray_w1 <= rgray;
      rgray_w2 <= rgray_w1;
      if (push) begin
        wbin  <= wbin + PW'(1);
        wgray <= PW'(bin2gray(CNT_W'(wbin + PW'(1))));
      end
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wgray_r1 <= '0; wgray_r2 <= '0;
    end else begin
      wgray_r1 <= wgray;
      wgray_r2 <= wgray_r1;
      if (pop) begin
        rbin  <= rbin + PW'(1);
        rgray <= PW'(bin2gray(CNT_W'(rbin + PW'(1))));
      end
    end
  end

  generate
    if (HOST_IS_WRITER) begin : g_wocc
      assign host_occ = CNT_W'(wocc);
    end else begin : g_rocc
      assign host_occ = CNT_W'(rocc);
    end
  endgenerate
endmodule

// File: rtl/tmb_desc_framer.sv
module tmb_desc_framer #(
  parameter int unsigned ARG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             pop,
  input  logic [ARG_W-1:0] cnt_field,
  output logic             first,
  output logic             last,
  output logic             done
);
  logic             busy;
  logic [ARG_W-1:0] left;
  logic             take;

  assign take  = pop & valid;
  assign first = ~busy;
  assign last  = busy ? (left == ARG_W'(1)) : (cnt_field == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; left <= '0; done <= 1'b0;
    end else begin
      done <= take & last;
      if (take) begin
        if (first) begin
          left <= cnt_field;
          busy <= (cnt_field != '0);
        end else begin
          left <= left - ARG_W'(1);
          busy <= (left != ARG_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/task_mbox_if.sv
module task_mbox_if #(
  parameter int unsigned AW    = 4,
  parameter int unsigned ARG_W = 8
) (
  input  logic        h_clk,
  input  logic        h_rst_n,
  input  logic        h_wr_en,
  input  logic        h_rd_en,
  input  logic [2:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  input  logic        c_clk,
  input  logic        c_rst_n,
  input  logic        c_new_pop,
  output logic        c_new_valid,
  output logic [31:0] c_new_word,
  output logic        c_new_first,
  output logic        c_new_last,
  output logic        c_desc_done,
  input  logic        c_rdy_push,
  input  logic [31:0] c_rdy_word,
  output logic        c_rdy_full,
  input  logic        c_fin_pop,
  output logic        c_fin_valid,
  output logic [31:0] c_fin_id
);
  import tmb_pkg::*;

  logic        wr_new, wr_fin, rd_rdy;
  logic        new_full, new_empty, fin_full, fin_empty, rdy_empty;
  logic [15:0] new_occ, fin_occ, rdy_occ;
  logic [31:0] rdy_head;
  logic [2:0]  err_q;   // 0 new, 1 ready, 2 finished

  assign wr_new = h_wr_en && (h_addr == A_NEW_DATA);
  assign wr_fin = h_wr_en && (h_addr == A_FIN_DATA);
  assign rd_rdy = h_rd_en && (h_addr == A_RDY_DATA);

  tmb_async_fifo #(.W(WORD_W), .AW(AW), .HOST_IS_WRITER(1'b1)) new_q (
    .wclk(h_clk), .wrst_n(h_rst_n), .wen(wr_new), .wdata(h_wdata), .wfull(new_full),
    .rclk(c_clk), .rrst_n(c_rst_n), .ren(c_new_pop), .rdata(c_new_word),
    .rempty(new_empty), .host_occ(new_occ));

  tmb_async_fifo #(.W(WORD_W), .AW(AW), .HOST_IS_WRITER(1'b0)) rdy_q (
    .wclk(c_clk), .wrst_n(c_rst_n), .wen(c_rdy_push), .wdata(c_rdy_word), .wfull(c_rdy_full),
    .rclk(h_clk), .rrst_n(h_rst_n), .ren(rd_rdy), .rdata(rdy_head),
    .rempty(rdy_empty), .host_occ(rdy_occ));

  tmb_async_fifo #(.W(WORD_W), .AW(AW), .HOST_IS_WRITER(1'b1)) fin_q (
    .wclk(h_clk), .wrst_n(h_rst_n), .wen(wr_fin), .wdata(h_wdata), .wfull(fin_full),
    .rclk(c_clk), .rrst_n(c_rst_n), .ren(c_fin_pop), .rdata(c_fin_id),
    .rempty(fin_empty), .host_occ(fin_occ));

  assign c_new_valid = ~new_empty;
  assign c_fin_valid = ~fin_empty;

  tmb_desc_framer #(.ARG_W(ARG_W)) framer (
    .clk(c_clk), .rst_n(c_rst_n), .valid(c_new_valid), .pop(c_new_pop),
    .cnt_field(c_new_word[ARG_W-1:0]), .first(c_new_first), .last(c_new_last),
    .done(c_desc_done));

  always_ff @(posedge h_clk or negedge h_rst_n) begin
    if (!h_rst_n) begin
      h_rdata <= '0;
      err_q   <= '0;
    end else begin
      if (h_rd_en) begin
        case (h_addr)
          A_NEW_STAT: h_rdata <= status_word(~new_full, err_q[0], new_occ);
          A_RDY_DATA: h_rdata <= rdy_empty ? '0 : rdy_head;
          A_RDY_STAT: h_rdata <= status_word(~rdy_empty, err_q[1], rdy_occ);
          A_FIN_STAT: h_rdata <= status_word(~fin_full, err_q[2], fin_occ);
          default:    h_rdata <= '0;
        endcase
      end
      if (wr_new && new_full)  err_q[0] <= 1'b1;
      if (rd_rdy && rdy_empty) err_q[1] <= 1'b1;
      if (wr_fin && fin_full)  err_q[2] <= 1'b1;
    end
  end
endmodule

// File: rtl/tmb_chk.sv
module tmb_chk #(
  parameter int unsigned AW = 4
) (
  input logic        h_clk,
  input logic        h_rst_n,
  input logic        c_clk,
  input logic        c_rst_n,
  input logic        h_rd_en,
  input logic [2:0]  h_addr,
  input logic [31:0] h_rdata,
  input logic        rdy_empty,
  input logic [15:0] new_occ,
  input logic [15:0] fin_occ,
  input logic [2:0]  err_q,
  input logic        c_new_pop,
  input logic        c_new_valid,
  input logic        c_new_last,
  input logic        c_desc_done
);
  localparam logic [15:0] DEPTH = 16'(1 << AW);

  // R7
  new_occ_bound_chk: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    new_occ <= DEPTH);

  // R7
  fin_occ_bound_chk: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    fin_occ <= DEPTH);

  // R8
  empty_read_zero_chk: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    (h_rd_en && h_addr == 3'd2 && rdy_empty) |=> (h_rdata == 32'd0));

  // R10
  err_sticky_chk: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    (err_q != 3'd0) |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R4
  done_after_last_chk: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    c_desc_done |-> $past(c_new_pop && c_new_valid && c_new_last));
endmodule

bind task_mbox_if tmb_chk #(.AW(AW)) chk_i (
  .h_clk(h_clk), .h_rst_n(h_rst_n), .c_clk(c_clk), .c_rst_n(c_rst_n),
  .h_rd_en(h_rd_en), .h_addr(h_addr), .h_rdata(h_rdata), .rdy_empty(rdy_empty),
  .new_occ(new_occ), .fin_occ(fin_occ), .err_q(err_q),
  .c_new_pop(c_new_pop), .c_new_valid(c_new_valid), .c_new_last(c_new_last),
  .c_desc_done(c_desc_done));

// File: tb/task_mbox_if_tb.sv
`timescale 1ns/1ps
module task_mbox_if_tb_top;
  localparam int AW = 2;
  localparam int DEPTH = 1 << AW;

  logic        h_clk = 0, c_clk = 0, h_rst_n = 0, c_rst_n = 0;
  logic        h_wr_en = 0, h_rd_en = 0;
  logic [2:0]  h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic        c_new_pop = 0, c_new_valid, c_new_first, c_new_last, c_desc_done;
  logic [31:0] c_new_word;
  logic        c_rdy_push = 0, c_rdy_full;
  logic [31:0] c_rdy_word = 0;
  logic        c_fin_pop = 0, c_fin_valid;
  logic [31:0] c_fin_id;
  int total = 0, bad = 0;

  always #2.5 h_clk = ~h_clk;
  always #20  c_clk = ~c_clk;

  task_mbox_if #(.AW(AW), .ARG_W(8)) dut_i (.*);

  function automatic logic [31:0] stat(input bit ok, input bit err, input int occ);
    return (32'(ok) << 31) | (32'(err) << 30) | 32'(occ);
  endfunction
  function automatic logic [31:0] dword(input int n, input int k);
    return (k == 0) ? ((32'hA00000 + 32'(n)) << 8) | 32'(n)
                    : 32'hB000_0000 | (32'(n) << 8) | 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge h_clk); h_wr_en = 1; h_addr = a; h_wdata = d;
    @(negedge h_clk); h_wr_en = 0;
  endtask
  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    @(negedge h_clk); h_rd_en = 1; h_addr = a;
    @(negedge h_clk); h_rd_en = 0; d = h_rdata;
  endtask
  task automatic hstat(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    hread(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic cpop_new(input logic [31:0] w, input bit f, input bit l, input string req);
    @(negedge c_clk);
    while (!c_new_valid) @(negedge c_clk);
    chk(c_new_word == w, req, c_new_word, w);
    chk({c_new_first, c_new_last} == {f, l}, "R4 flags", 32'({c_new_first, c_new_last}), 32'({f, l}));
    c_new_pop = 1;
    @(negedge c_clk); c_new_pop = 0;
    chk(c_desc_done == l, "R4 done", 32'(c_desc_done), 32'(l));
  endtask

  task automatic cpush_rdy(input logic [31:0] w);
    @(negedge c_clk); c_rdy_push = 1; c_rdy_word = w;
    @(negedge c_clk); c_rdy_push = 0;
  endtask

  initial begin
    repeat (100000) @(posedge h_clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge c_clk);
    h_rst_n = 1; c_rst_n = 1;
    repeat (2) @(negedge c_clk);
    // R9 / R1 / R2 reset state through each status address
    hstat(3'd1, stat(1, 0, 0), "R9 R1 new status");
    hstat(3'd3, stat(0, 0, 0), "R9 R1 ready status");
    hstat(3'd5, stat(1, 0, 0), "R9 R1 fin status");
    hstat(3'd6, 32'd0, "R1 unmapped");
    chk(!c_new_valid && !c_fin_valid && !c_desc_done, "R9 core valids", 32'(c_new_valid), 0);
    // R8 empty read
    hread(3'd2, d); chk(d == 0, "R8 empty read", d, 0);
    hstat(3'd3, stat(0, 1, 0), "R8 R2 ready err");
    // R3 fill new queue with one descriptor n=3
    for (int k = 0; k < DEPTH; k++) begin
      hwrite(3'd0, dword(3, k));
      hstat(3'd1, stat(k + 1 < DEPTH, 0, k + 1), "R3 occupancy");
    end
    // R7 overflow
    hwrite(3'd0, 32'hDEAD_BEEF);
    hstat(3'd1, stat(0, 1, DEPTH), "R7 new overflow");
    for (int k = 0; k < DEPTH; k++) cpop_new(dword(3, k), k == 0, k == 3, "R3 R7 order");
    repeat (4) @(negedge c_clk);
    chk(!c_new_valid, "R7 dropped word", 32'(c_new_valid), 0);
    hstat(3'd1, stat(1, 1, 0), "R10 sticky new err");
    hstat(3'd5, stat(1, 0, 0), "R10 fin err independent");
    // R4 sweep of argument counts with concurrent drain
    fork
      begin
        for (int n = 0; n < 6; n++)
          for (int k = 0; k <= n; k++) begin
            d = 0;
            while (!d[31]) hread(3'd1, d);
            hwrite(3'd0, dword(n, k));
          end
      end
      begin
        for (int n = 0; n < 6; n++)
          for (int k = 0; k <= n; k++) cpop_new(dword(n, k), k == 0, k == n, "R4 sweep word");
      end
    join
    hstat(3'd1, stat(1, 1, 0), "R4 drained");
    // R5 ready queue
    for (int k = 0; k <= DEPTH; k++) begin
      if (k == DEPTH) chk(c_rdy_full, "R5 full flag", 32'(c_rdy_full), 1);
      cpush_rdy(32'h5000_0000 + 32'(k));
    end
    repeat (20) @(negedge h_clk);
    hstat(3'd3, stat(1, 1, DEPTH), "R5 ready occupancy");
    for (int k = 0; k < DEPTH; k++) begin
      hread(3'd2, d); chk(d == 32'h5000_0000 + 32'(k), "R5 ready order", d, 32'h5000_0000 + 32'(k));
    end
    hread(3'd2, d); chk(d == 0, "R5 R8 dropped push", d, 0);
    hstat(3'd3, stat(0, 1, 0), "R5 ready empty");
    // R6 finished queue, R7 overflow
    for (int k = 0; k < DEPTH; k++) begin
      hwrite(3'd4, 32'h7700 + 32'(k));
      hstat(3'd5, stat(k + 1 < DEPTH, 0, k + 1), "R6 fin occupancy");
    end
    hwrite(3'd4, 32'hFFFF);
    hstat(3'd5, stat(0, 1, DEPTH), "R7 fin overflow");
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge c_clk);
      while (!c_fin_valid) @(negedge c_clk);
      chk(c_fin_id == 32'h7700 + 32'(k), "R6 fin order", c_fin_id, 32'h7700 + 32'(k));
      c_fin_pop = 1;
      @(negedge c_clk); c_fin_pop = 0;
    end
    repeat (4) @(negedge c_clk);
    chk(!c_fin_valid, "R7 fin dropped", 32'(c_fin_valid), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule